// File: doc/BRIEF.md
# GPIO Peripheral Register Bank Emulator

This block is a small slave on a power-management register bus. It stands in for four identical GPIO peripherals that sit behind one slave identifier. A requester presents a single-byte read or write, addressed by a slave identifier, a peripheral identifier and a register offset. The block answers exactly one cycle later with an acknowledge, an error flag and, for reads, a data byte.

Each bank holds a handful of live registers. Every live register carries its own write mask and its own read and write permissions. The remaining offsets inside the valid window are inert. Two side effects are modelled:
- A write to the control register can copy its low bit into the status register, depending on a two-bit mode field.
- Clearing the bank's enable register makes every read from that bank return zero. Writes keep working while the bank is disabled.

The block serves as a deterministic stand-in for a power-management device during driver bring-up and integration tests.

Top module: `gpioemu_regbank`

## Requirements
- R1: An access is valid only when the slave identifier is 0, the peripheral identifier lies in 0xC0..0xC3 and the offset is at most 0x46. Any other access answers with `rsp_error`=1 and `rsp_rdata`=0, and changes no register.
- R2: Every accepted request (`req_valid`=1 at a rising edge) gives `rsp_valid`=1 in the next cycle. `rsp_valid` is 0 in any cycle that follows no request. A valid access answers with `rsp_error`=0.
- R3: After reset, a bank reads these values: offset 0x04 gives 0x10, 0x05 gives 0x05, 0x08 gives 0x00, 0x40 gives 0x00, 0x41 gives 0x00, 0x42 gives 0x04, 0x45 gives 0x01 and 0x46 gives 0x80.
- R4: A write stores the written byte ANDed with the register's mask. The masks are 0x81 at 0x08, 0x7F at 0x40, 0x07 at 0x41 and 0x42, 0x3F at 0x45 and 0x80 at 0x46. The control register at 0x40 keeps its masked value for later reads.
- R5: A write to a register without write permission has no effect. Offsets 0x04 and 0x05 are read-only, and every offset not listed in R4 has neither permission.
- R6: Reading an offset without read permission returns 0x00 with no error, for example 0x00, 0x10 and 0x43.
- R7: A write to 0x40 whose masked bits [5:4] equal 01 or 10 replaces bit 0 of the status register 0x08 with bit 0 of the written byte. The modes 00 and 11 leave the status register unchanged.
- R8: While register 0x46 of a bank holds 0, every read from that bank returns 0x00. Writes to that bank still take effect.
- R9: Bits [1:0] of the peripheral identifier select the bank. A write to one bank is not visible in any other bank.
- R10: A write answers with `rsp_rdata`=0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sid | input | 4 | Slave identifier |
| req_pid | input | 8 | Peripheral identifier |
| req_off | input | 8 | Register offset inside the peripheral |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Acknowledge, one cycle after a request |
| rsp_error | output | 1 | Address was invalid |
| rsp_rdata | output | 8 | Read byte, zero for writes and errors |

## Verification
The vector table first reads every live register in several banks. This separates the reset values from one another and from the zero returned by inert offsets. All-ones writes then expose each mask and each missing write permission. Control writes cover all four mode values, with the low bit both set and cleared, so a side effect that triggers on the wrong mode or copies the wrong bit shows up in the following status read. The address sweep tests both neighbours of each valid range: peripheral identifiers 0xBF and 0xC4, offsets 0x46 and 0x47, and a non-zero slave identifier. A read-back after a rejected write confirms that no state changed. Directed tests then check back-to-back acknowledges, and check that a reset in the middle of operation restores the control and status values.

// File: rtl/gpioemu_pkg.sv
// gpioemu_pkg: register layout shared by the decoder and the banks.
// Assumes at most eight live registers per bank, so a slot index fits in three bits.
package gpioemu_pkg;

    localparam int SLOT_COUNT = 8;
    localparam int SLOT_W     = 3;

    // Live register slots of one bank
    localparam int SL_IDLO   = 0;
    localparam int SL_IDHI   = 1;
    localparam int SL_STATUS = 2;
    localparam int SL_CTRL   = 3;
    localparam int SL_CFGA   = 4;
    localparam int SL_CFGB   = 5;
    localparam int SL_DRIVE  = 6;
    localparam int SL_ENABLE = 7;

    // Bus offset of each slot
    function automatic logic [7:0] slot_offset(input int s);
        case (s)
            SL_IDLO:   return 8'h04;
            SL_IDHI:   return 8'h05;
            SL_STATUS: return 8'h08;
            SL_CTRL:   return 8'h40;
            SL_CFGA:   return 8'h41;
            SL_CFGB:   return 8'h42;
            SL_DRIVE:  return 8'h45;
            default:   return 8'h46;
        endcase
    endfunction

    // Write mask of each slot
    function automatic logic [7:0] slot_mask(input int s);
        case (s)
            SL_STATUS: return 8'h81;
            SL_CTRL:   return 8'h7F;
            SL_CFGA:   return 8'h07;
            SL_CFGB:   return 8'h07;
            SL_DRIVE:  return 8'h3F;
            SL_ENABLE: return 8'h80;
            default:   return 8'h00;
        endcase
    endfunction

    // Reset value of each slot
    function automatic logic [7:0] slot_init(input int s);
        case (s)
            SL_IDLO:   return 8'h10;
            SL_IDHI:   return 8'h05;
            SL_CFGB:   return 8'h04;
            SL_DRIVE:  return 8'h01;
            SL_ENABLE: return 8'h80;
            default:   return 8'h00;
        endcase
    endfunction

    // Write permission of each slot (every live slot is readable)
    function automatic logic slot_writable(input int s);
        return (s != SL_IDLO) && (s != SL_IDHI);
    endfunction

endpackage

// File: rtl/gpioemu_decode.sv
// gpioemu_decode: checks a request address and splits it into a bank
// index and a live-register slot.
// Assumes PID_BASE is aligned so that its low BANK_W bits are zero.
module gpioemu_decode
    import gpioemu_pkg::*;
#(
    parameter int SLAVE_ID  = 0,
    parameter int PID_BASE  = 8'hC0,
    parameter int NUM_BANKS = 4,
    parameter int LAST_OFF  = 8'h46,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [3:0]        sid,
    input  logic [7:0]        pid,
    input  logic [7:0]        off,
    output logic              addr_ok,
    output logic [BANK_W-1:0] bank_sel,
    output logic              slot_hit,
    output logic [SLOT_W-1:0] slot_sel
);

    localparam int PID_LAST = PID_BASE + NUM_BANKS - 1;

    // Range checks on the three address fields
    always_comb begin
        addr_ok = (int'(sid) == SLAVE_ID) &&
                  (int'(pid) >= PID_BASE) && (int'(pid) <= PID_LAST) &&
                  (int'(off) <= LAST_OFF);
        bank_sel = pid[BANK_W-1:0];
    end

    // Find which live slot, if any, the offset names
    always_comb begin
        slot_hit = 1'b0;
        slot_sel = '0;
        for (int s = 0; s < SLOT_COUNT; s++) begin
            if (off == slot_offset(s)) begin
                slot_hit = 1'b1;
                slot_sel = SLOT_W'(s);
            end
        end
    end

endmodule

// File: rtl/gpioemu_bank.sv
// gpioemu_bank: the live registers of one emulated GPIO peripheral.
// Applies masks, write permissions, the control-to-status side effect and the read gate.
// Assumes the caller asserts wr_stb only for a valid address in this bank.
module gpioemu_bank
    import gpioemu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              slot_hit,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_value
);

    logic [7:0] regs [SLOT_COUNT];
    logic       ctrl_wr;
    logic [7:0] ctrl_val;
    logic       mode_copy;

    // Decode a control write and its mode field
    always_comb begin
        ctrl_wr   = wr_stb && slot_hit && (int'(slot_sel) == SL_CTRL);
        ctrl_val  = wdata & slot_mask(SL_CTRL);
        mode_copy = (ctrl_val[5:4] == 2'b01) || (ctrl_val[5:4] == 2'b10);
    end

    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        if (!slot_writable(s)) begin : g_ro
            // Read-only slot keeps its reset value
            always_ff @(posedge clk) begin
                regs[s] <= slot_init(s);
            end
        end else if (s == SL_STATUS) begin : g_status
            // Status: direct masked write or bit-0 copy from a control write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[s] <= slot_init(s);
                else if (wr_stb && slot_hit && (int'(slot_sel) == s))
                    regs[s] <= wdata & slot_mask(s);
                else if (ctrl_wr && mode_copy)
                    regs[s] <= {regs[s][7:1], ctrl_val[0]};
            end
        end else begin : g_rw
            // Plain masked read/write register
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[s] <= slot_init(s);
                else if (wr_stb && slot_hit && (int'(slot_sel) == s))
                    regs[s] <= wdata & slot_mask(s);
            end
        end
    end

    // Read path gated by the bank enable register
    always_comb begin
        if (regs[SL_ENABLE] == 8'h00 || !slot_hit)
            rd_value = 8'h00;
        else
            rd_value = regs[slot_sel];
    end

    // No register may move in a cycle without a write strobe (R5)
    assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> (regs[SL_STATUS] == $past(regs[SL_STATUS])) &&
                    (regs[SL_CTRL] == $past(regs[SL_CTRL])) &&
                    (regs[SL_ENABLE] == $past(regs[SL_ENABLE])));

    // A copying control write lands its bit 0 in the status register (R7)
    assert_ctrl_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && mode_copy) |=> (regs[SL_STATUS][0] == $past(wdata[0])));

    // A non-copying control write leaves the status register alone (R7)
    assert_ctrl_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !mode_copy) |=> $stable(regs[SL_STATUS]));

endmodule

// File: rtl/gpioemu_regbank.sv
// gpioemu_regbank: top of the emulated GPIO register bank.
// Decodes each request, steers writes to one bank and registers a one-cycle response.
// Assumes single-byte requests and that the requester accepts every response.
module gpioemu_regbank
    import gpioemu_pkg::*;
#(
    parameter int SLAVE_ID  = 0,
    parameter int PID_BASE  = 8'hC0,
    parameter int NUM_BANKS = 4,
    parameter int LAST_OFF  = 8'h46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [3:0] req_sid,
    input  logic [7:0] req_pid,
    input  logic [7:0] req_off,
    input  logic [7:0] req_wdata,
    output logic       rsp_valid,
    output logic       rsp_error,
    output logic [7:0] rsp_rdata
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic              addr_ok;
    logic [BANK_W-1:0] bank_sel;
    logic              slot_hit;
    logic [SLOT_W-1:0] slot_sel;
    logic [7:0]        bank_rd [NUM_BANKS];
    logic [7:0]        rd_mux;

    gpioemu_decode #(
        .SLAVE_ID (SLAVE_ID),
        .PID_BASE (PID_BASE),
        .NUM_BANKS(NUM_BANKS),
        .LAST_OFF (LAST_OFF)
    ) u_decode (
        .sid     (req_sid),
        .pid     (req_pid),
        .off     (req_off),
        .addr_ok (addr_ok),
        .bank_sel(bank_sel),
        .slot_hit(slot_hit),
        .slot_sel(slot_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpioemu_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (req_valid && req_write && addr_ok && (int'(bank_sel) == b)),
            .slot_hit(slot_hit),
            .slot_sel(slot_sel),
            .wdata   (req_wdata),
            .rd_value(bank_rd[b])
        );
    end

    // Pick the read value of the addressed bank
    always_comb begin
        rd_mux = 8'h00;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank_sel) == b)
                rd_mux = bank_rd[b];
        end
    end

    // Register the response one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= 8'h00;
        end else begin
            rsp_valid <= req_valid;
            rsp_error <= req_valid && !addr_ok;
            rsp_rdata <= (req_valid && !req_write && addr_ok) ? rd_mux : 8'h00;
        end
    end

    // Every request is acknowledged in the next cycle (R2)
    assert_ack_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // No acknowledge without a request (R2)
    assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // A foreign slave identifier always ends in an error (R1)
    assert_foreign_sid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_sid) != SLAVE_ID) |=> rsp_error);

    // An error response carries no data (R1)
    assert_err_no_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_rdata == 8'h00));

    // A write response carries no data (R10)
    assert_write_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 8'h00));

endmodule

// File: tb/gpioemu_regbank_test.sv
module gpioemu_regbank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_sid = '0;
    logic [7:0] req_pid = '0;
    logic [7:0] req_off = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic       rsp_error;
    logic [7:0] rsp_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpioemu_regbank uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_sid(req_sid), .req_pid(req_pid), .req_off(req_off),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata)
    );

    // Vector: {req tag(4), write(1), sid(4), pid(8), off(8), wdata(8), exp_err(1), exp_data(8)}
    localparam int NV = 38;
    localparam logic [41:0] VEC [NV] = '{
        {4'd3, 1'b0, 4'h0, 8'hC0, 8'h04, 8'h00, 1'b0, 8'h10}, // R3
        {4'd3, 1'b0, 4'h0, 8'hC0, 8'h05, 8'h00, 1'b0, 8'h05}, // R3
        {4'd3, 1'b0, 4'h0, 8'hC1, 8'h42, 8'h00, 1'b0, 8'h04}, // R3
        {4'd3, 1'b0, 4'h0, 8'hC2, 8'h45, 8'h00, 1'b0, 8'h01}, // R3
        {4'd3, 1'b0, 4'h0, 8'hC3, 8'h46, 8'h00, 1'b0, 8'h80}, // R3
        {4'd3, 1'b0, 4'h0, 8'hC0, 8'h08, 8'h00, 1'b0, 8'h00}, // R3
        {4'd10,1'b1, 4'h0, 8'hC0, 8'h41, 8'hFF, 1'b0, 8'h00}, // R10
        {4'd4, 1'b0, 4'h0, 8'hC0, 8'h41, 8'h00, 1'b0, 8'h07}, // R4
        {4'd5, 1'b1, 4'h0, 8'hC0, 8'h04, 8'hAA, 1'b0, 8'h00}, // R5
        {4'd5, 1'b0, 4'h0, 8'hC0, 8'h04, 8'h00, 1'b0, 8'h10}, // R5
        {4'd6, 1'b0, 4'h0, 8'hC0, 8'h10, 8'h00, 1'b0, 8'h00}, // R6
        {4'd5, 1'b1, 4'h0, 8'hC0, 8'h43, 8'hFF, 1'b0, 8'h00}, // R5
        {4'd6, 1'b0, 4'h0, 8'hC0, 8'h43, 8'h00, 1'b0, 8'h00}, // R6
        {4'd7, 1'b1, 4'h0, 8'hC1, 8'h40, 8'h91, 1'b0, 8'h00}, // R7 mode 01 bit0 1
        {4'd7, 1'b0, 4'h0, 8'hC1, 8'h08, 8'h00, 1'b0, 8'h01}, // R7
        {4'd4, 1'b0, 4'h0, 8'hC1, 8'h40, 8'h00, 1'b0, 8'h11}, // R4
        {4'd7, 1'b1, 4'h0, 8'hC1, 8'h40, 8'hB0, 1'b0, 8'h00}, // R7 mode 11
        {4'd7, 1'b0, 4'h0, 8'hC1, 8'h08, 8'h00, 1'b0, 8'h01}, // R7
        {4'd7, 1'b1, 4'h0, 8'hC1, 8'h40, 8'h20, 1'b0, 8'h00}, // R7 mode 10 bit0 0
        {4'd7, 1'b0, 4'h0, 8'hC1, 8'h08, 8'h00, 1'b0, 8'h00}, // R7
        {4'd9, 1'b0, 4'h0, 8'hC2, 8'h40, 8'h00, 1'b0, 8'h00}, // R9
        {4'd4, 1'b1, 4'h0, 8'hC2, 8'h08, 8'hFF, 1'b0, 8'h00}, // R4
        {4'd4, 1'b0, 4'h0, 8'hC2, 8'h08, 8'h00, 1'b0, 8'h81}, // R4
        {4'd8, 1'b1, 4'h0, 8'hC3, 8'h46, 8'h7F, 1'b0, 8'h00}, // R8 enable cleared
        {4'd8, 1'b0, 4'h0, 8'hC3, 8'h45, 8'h00, 1'b0, 8'h00}, // R8
        {4'd8, 1'b0, 4'h0, 8'hC3, 8'h04, 8'h00, 1'b0, 8'h00}, // R8
        {4'd9, 1'b0, 4'h0, 8'hC2, 8'h04, 8'h00, 1'b0, 8'h10}, // R9
        {4'd8, 1'b1, 4'h0, 8'hC3, 8'h45, 8'h0A, 1'b0, 8'h00}, // R8
        {4'd8, 1'b1, 4'h0, 8'hC3, 8'h46, 8'h80, 1'b0, 8'h00}, // R8
        {4'd8, 1'b0, 4'h0, 8'hC3, 8'h45, 8'h00, 1'b0, 8'h0A}, // R8
        {4'd1, 1'b0, 4'h1, 8'hC0, 8'h04, 8'h00, 1'b1, 8'h00}, // R1
        {4'd1, 1'b0, 4'h0, 8'hC4, 8'h04, 8'h00, 1'b1, 8'h00}, // R1
        {4'd1, 1'b0, 4'h0, 8'hBF, 8'h04, 8'h00, 1'b1, 8'h00}, // R1
        {4'd1, 1'b0, 4'h0, 8'hC0, 8'h47, 8'h00, 1'b1, 8'h00}, // R1
        {4'd1, 1'b0, 4'h0, 8'hC0, 8'h46, 8'h00, 1'b0, 8'h80}, // R1
        {4'd1, 1'b1, 4'h0, 8'hC0, 8'h47, 8'hFF, 1'b1, 8'h00}, // R1
        {4'd1, 1'b1, 4'h2, 8'hC0, 8'h41, 8'h00, 1'b1, 8'h00}, // R1
        {4'd1, 1'b0, 4'h0, 8'hC0, 8'h41, 8'h00, 1'b0, 8'h07}  // R1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One request: drive at a falling edge, sample the response one cycle later
    task automatic access(input logic wr, input logic [3:0] sid, input logic [7:0] pid,
                          input logic [7:0] off, input logic [7:0] wd,
                          output logic v, output logic e, output logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_sid = sid;
        req_pid = pid; req_off = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        v = rsp_valid; e = rsp_error; d = rsp_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic v, e;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state: no response pending
        check("R2 reset rsp_valid", 32'(rsp_valid), 0);
        check("R1 reset rsp_error", 32'(rsp_error), 0);

        for (int i = 0; i < NV; i++) begin
            logic [41:0] t;
            string tag;
            t = VEC[i];
            access(t[37], t[36:33], t[32:25], t[24:17], t[16:9], v, e, d);
            tag = $sformatf("R%0d vec%0d", t[41:38], i);
            check({tag, " valid"}, 32'(v), 1);
            check({tag, " error"}, 32'(e), 32'(t[8]));
            check({tag, " data"}, 32'(d), 32'(t[7:0]));
        end

        // R2: back-to-back requests each acknowledged, then idle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_sid = 4'h0; req_pid = 8'hC0; req_off = 8'h05;
        @(negedge clk);
        check("R2 b2b first valid", 32'(rsp_valid), 1);
        check("R2 b2b first data", 32'(rsp_rdata), 32'h05);
        req_pid = 8'hC3; req_off = 8'h42;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 b2b second valid", 32'(rsp_valid), 1);
        check("R2 b2b second data", 32'(rsp_rdata), 32'h04);
        @(negedge clk);
        check("R2 idle valid", 32'(rsp_valid), 0);

        // R3: reset mid-operation restores control and status
        access(1'b1, 4'h0, 8'hC1, 8'h40, 8'h11, v, e, d);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, 4'h0, 8'hC1, 8'h40, 8'h00, v, e, d);
        check("R3 ctrl after reset", 32'(d), 0);
        access(1'b0, 4'h0, 8'hC1, 8'h08, 8'h00, v, e, d);
        check("R3 status after reset", 32'(d), 0);

        // R7 mode 00 leaves status unchanged
        access(1'b1, 4'h0, 8'hC2, 8'h40, 8'h01, v, e, d);
        access(1'b0, 4'h0, 8'hC2, 8'h08, 8'h00, v, e, d);
        check("R7 mode 00 keeps status", 32'(d), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule